// File: doc/BRIEF.md
# Parallel-Port 1-Wire Host Interface

This block sits between a PC parallel port and a 1-Wire timing engine inside a stackable port adapter. The host picks an operation with two select levels (a data/clock line and a reset-select line), then starts it by pulling an active-low enable low. The block decodes the operation, either hands it to the timing engine as a one-cycle start pulse with an operation code, or toggles its overdrive mode bit locally. It reports progress and the sampled bus level back on two active-low status lines.

The same two status lines also carry the signals of whatever sits further down the port, such as a printer or another adapter, so that several adapters can share one port. Every reset slot doubles as a probe of the chain: if no downstream adapter signals busy while the reset runs, the block takes itself to be the last device. From then on it ignores the downstream inputs while enable is low and holds its enable-out high so that nothing downstream sees a strobe.

All host and downstream inputs are asynchronous and pass through synchronizers. Edges are detected on the synchronized enable.

Top module: `owire_host_if`

## Requirements
- R1: After reset the overdrive bit is 0, no start pulse is issued, the block is not the last device (en_out_n follows host_en_n), and with enable high the status outputs equal dn_in1/dn_in2.
- R2: On a falling enable the select levels are decoded and a start pulse of exactly one cycle is issued with eng_op = 2'b00 for data/clock high and reset-select high (read or write-1), 2'b01 for data/clock low and reset-select high (write-0), and 2'b10 for data/clock high and reset-select low (reset).
- R3: From the start of a slot until eng_done, both status outputs are driven low.
- R4: After eng_done, with enable low and data/clock high, the status outputs follow dn_in1/dn_in2 (or read high when the block is the last device).
- R5: After eng_done, while data/clock is low, both status outputs are low if eng_level was 0 at completion; if it was 1 they show the pass-through value.
- R6: The low result state ends when data/clock returns high or enable returns high; with enable high the status outputs equal dn_in1/dn_in2.
- R7: Both select levels low on a falling enable toggle the overdrive bit (shown on eng_ovd) without a start pulse; until enable rises the status outputs show the pass-through value if the bit became 1 and are both low if it became 0.
- R8: When a reset slot completes, the block becomes the last device if dn_in1 and dn_in2 were never both low (after synchronization) during the slot, counting the cycle in which eng_done arrives; otherwise it becomes not last.
- R9: As last device the block drives both status outputs high wherever they would pass dn_in1/dn_in2 while enable is low, and holds en_out_n high; when not last, en_out_n equals host_en_n.
- R10: A running slot keeps the status outputs low until eng_done even if enable returns high during it; a completion with enable already high returns straight to pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_dclk | input | 1 | Host data/clock select and result query line |
| host_rsel | input | 1 | Host reset-select line |
| host_en_n | input | 1 | Host active-low enable |
| dn_in1 | input | 1 | Downstream status input 1 (printer busy or next adapter) |
| dn_in2 | input | 1 | Downstream status input 2 (printer select or next adapter) |
| eng_done | input | 1 | Timing engine completion pulse |
| eng_level | input | 1 | Bus level sampled by the engine, valid with eng_done |
| eng_start | output | 1 | One-cycle start pulse to the timing engine |
| eng_op | output | 2 | Operation code valid with eng_start |
| eng_ovd | output | 1 | Overdrive timing select |
| stat1_n | output | 1 | Active-low status/busy line 1 to host |
| stat2_n | output | 1 | Active-low status/busy line 2 to host |
| en_out_n | output | 1 | Enable passed to the downstream adapter |

## Verification
Two functions can meet in one clock: the completion of a reset slot and the first cycle in which a downstream adapter's busy (both downstream inputs low) emerges from the synchronizer. The bench provokes this by pulling both downstream inputs low exactly two cycles before it pulses eng_done, after an earlier reset has made the block last, so the busy is visible only in the done cycle. It judges the result at the ports: en_out_n must again follow the enable while enable is held low, showing that the coincident busy was counted.

// File: rtl/owh_pkg.sv
// Shared types for the parallel-port 1-Wire host interface.
// Assumes: operation codes are consumed by a separate timing engine.
package owh_pkg;

    // Operation codes sent with the start pulse
    typedef enum logic [1:0] {
        OP_RW1 = 2'b00,
        OP_WR0 = 2'b01,
        OP_RST = 2'b10,
        OP_TGL = 2'b11
    } op_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01,
        ST_DONE = 2'b10,
        ST_TOGG = 2'b11
    } state_e;

    // Map the two select levels to an operation
    function automatic op_e decode_op(input logic dclk, input logic rsel);
        op_e r;
        case ({dclk, rsel})
            2'b11:   r = OP_RW1;
            2'b01:   r = OP_WR0;
            2'b10:   r = OP_RST;
            default: r = OP_TGL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/owh_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independent; reset loads RESET_VAL into every stage.
module owh_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later flops shift the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/owh_seq.sv
// Slot sequencer: detects the enable fall, decodes the operation, starts the
// timing engine or toggles overdrive, captures the result and decides whether
// this adapter is the last one on the chain.
// Assumes: inputs are already synchronized; the engine answers every start
// with exactly one done pulse.
module owh_seq
    import owh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s_n,
    input  logic       dclk_s,
    input  logic       rsel_s,
    input  logic [1:0] dn_s,
    input  logic       eng_done,
    input  logic       eng_level,
    output state_e     state,
    output logic       ovd,
    output logic       last_dev,
    output logic       res_low,
    output logic       start,
    output op_e        op
);
    logic   en_prev_n;
    logic   fall;
    op_e    cmd;
    logic   dn_busy;
    logic   seen_busy;

    assign fall    = en_prev_n & ~en_s_n;
    assign cmd     = decode_op(dclk_s, rsel_s);
    assign dn_busy = (dn_s == 2'b00);

    // Remember last synchronized enable for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev_n <= 1'b1;
        else        en_prev_n <= en_s_n;
    end

    // Main slot state machine with mode, result and chain-position state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ovd       <= 1'b0;
            last_dev  <= 1'b0;
            res_low   <= 1'b0;
            start     <= 1'b0;
            op        <= OP_RW1;
            seen_busy <= 1'b0;
        end else begin
            start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        if (cmd == OP_TGL) begin
                            ovd   <= ~ovd;
                            state <= ST_TOGG;
                        end else begin
                            start     <= 1'b1;
                            op        <= cmd;
                            seen_busy <= 1'b0;
                            state     <= ST_BUSY;
                        end
                    end
                end
                ST_BUSY: begin
                    if (op == OP_RST && dn_busy) seen_busy <= 1'b1;
                    if (eng_done) begin
                        res_low <= ~eng_level;
                        if (op == OP_RST) last_dev <= ~(seen_busy | dn_busy);
                        state <= en_s_n ? ST_IDLE : ST_DONE;
                    end
                end
                ST_DONE, ST_TOGG: begin
                    if (en_s_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: start pulse lasts one cycle
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R7: a toggle command never starts the engine
    p_toggle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fall && cmd == OP_TGL) |=> !start);

    // R7: overdrive changes only after a toggle command
    p_ovd_only_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovd) |-> $past(state == ST_IDLE && fall && cmd == OP_TGL));

    // R10: a running slot is left only on completion
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !eng_done) |=> state == ST_BUSY);

endmodule

// File: rtl/owh_status.sv
// Status line multiplexer: chooses between busy, result, overdrive report and
// pass-through of the downstream lines, with the last-device override.
// Assumes: dn_raw is passed combinationally so printer signals are not delayed.
module owh_status
    import owh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  state_e     state,
    input  logic       ovd,
    input  logic       last_dev,
    input  logic       res_low,
    input  logic       en_s_n,
    input  logic       dclk_s,
    input  logic [1:0] dn_raw,
    output logic [1:0] stat_n
);
    logic [1:0] pass;

    // Pass-through value, forced high for the last device while enabled
    always_comb begin
        pass = (last_dev && !en_s_n) ? 2'b11 : dn_raw;
    end

    // Select the status line value from the slot state
    always_comb begin
        case (state)
            ST_BUSY: stat_n = 2'b00;
            ST_DONE: stat_n = (!dclk_s && res_low) ? 2'b00 : pass;
            ST_TOGG: stat_n = ovd ? pass : 2'b00;
            default: stat_n = pass;
        endcase
    end

    // R3: busy indication during a slot
    p_busy_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (stat_n == 2'b00));

    // R9: last device never passes a low downstream line while enabled
    p_last_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_dev && !en_s_n && state == ST_IDLE) |-> (stat_n == 2'b11));

endmodule

// File: rtl/owire_host_if.sv
// Top of the parallel-port 1-Wire host interface. Synchronizes host and
// downstream inputs, runs the slot sequencer and drives the status lines and
// the downstream enable.
// Assumes: the timing engine and pad pull-ups live outside this block.
module owire_host_if
    import owh_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_dclk,
    input  logic       host_rsel,
    input  logic       host_en_n,
    input  logic       dn_in1,
    input  logic       dn_in2,
    input  logic       eng_done,
    input  logic       eng_level,
    output logic       eng_start,
    output logic [1:0] eng_op,
    output logic       eng_ovd,
    output logic       stat1_n,
    output logic       stat2_n,
    output logic       en_out_n
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] sync_q;
    logic             en_s_n, dclk_s, rsel_s;
    logic [1:0]       dn_s;
    state_e           state;
    logic             ovd, last_dev, res_low, start;
    op_e              op;
    logic [1:0]       stat_n;

    owh_sync #(
        .WIDTH    (NSYNC),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL({NSYNC{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({host_en_n, host_dclk, host_rsel, dn_in2, dn_in1}),
        .q_sync (sync_q)
    );

    assign {en_s_n, dclk_s, rsel_s, dn_s} = sync_q;

    owh_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s_n   (en_s_n),
        .dclk_s   (dclk_s),
        .rsel_s   (rsel_s),
        .dn_s     (dn_s),
        .eng_done (eng_done),
        .eng_level(eng_level),
        .state    (state),
        .ovd      (ovd),
        .last_dev (last_dev),
        .res_low  (res_low),
        .start    (start),
        .op       (op)
    );

    owh_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .ovd     (ovd),
        .last_dev(last_dev),
        .res_low (res_low),
        .en_s_n  (en_s_n),
        .dclk_s  (dclk_s),
        .dn_raw  ({dn_in2, dn_in1}),
        .stat_n  (stat_n)
    );

    assign eng_start = start;
    assign eng_op    = op;
    assign eng_ovd   = ovd;
    assign stat1_n   = stat_n[0];
    assign stat2_n   = stat_n[1];

    // Downstream enable: held high by the last device, else passed through
    always_comb begin
        en_out_n = last_dev ? 1'b1 : host_en_n;
    end

    // R2: start carries a real engine operation
    p_start_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_op != 2'b11));

endmodule

// File: tb/owire_host_if_test.sv
module owire_host_if_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_dclk = 1'b1, host_rsel = 1'b1, host_en_n = 1'b1;
    logic       dn_in1 = 1'b0, dn_in2 = 1'b1;
    logic       eng_done = 1'b0, eng_level = 1'b1;
    logic       eng_start, eng_ovd, stat1_n, stat2_n, en_out_n;
    logic [1:0] eng_op;

    int n_chk = 0, n_bad = 0, n_start = 0;
    bit m_last = 0, m_ovd = 0;

    owire_host_if uut (
        .clk(clk), .rst_n(rst_n), .host_dclk(host_dclk), .host_rsel(host_rsel),
        .host_en_n(host_en_n), .dn_in1(dn_in1), .dn_in2(dn_in2),
        .eng_done(eng_done), .eng_level(eng_level), .eng_start(eng_start),
        .eng_op(eng_op), .eng_ovd(eng_ovd), .stat1_n(stat1_n),
        .stat2_n(stat2_n), .en_out_n(en_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (eng_start) n_start++;

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [1:0] f_pass(input bit last, input bit en_low, input logic [1:0] dn);
        return (last && en_low) ? 2'b11 : dn;
    endfunction

    function automatic logic [1:0] f_code(input logic dclk, input logic rsel);
        case ({dclk, rsel})
            2'b11: return 2'b00;
            2'b01: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] stat();
        return {stat2_n, stat1_n};
    endfunction

    // Run one host operation; dn held constant through the slot
    task automatic do_slot(input logic dclk, input logic rsel, input logic [1:0] dn,
                           input logic level, input bit abort_mid);
        int s0;
        bit got;
        @(negedge clk);
        host_dclk = dclk; host_rsel = rsel; {dn_in2, dn_in1} = dn;
        wait_n(3);
        s0 = n_start;
        host_en_n = 1'b0;
        if (!dclk && !rsel) begin
            wait_n(6);
            m_ovd = !m_ovd;
            check("R7 no start", 4'(n_start - s0), 4'd0);
            check("R7 ovd", {3'b0, eng_ovd}, {3'b0, m_ovd});
            check("R7 status", {2'b0, stat()}, {2'b0, m_ovd ? f_pass(m_last, 1, dn) : 2'b00});
            check("R9 eno", {3'b0, en_out_n}, {3'b0, m_last});
        end else begin
            got = 0;
            for (int i = 0; i < 10 && !got; i++) begin
                @(negedge clk);
                if (eng_start) begin
                    got = 1;
                    check("R2 op", {2'b0, eng_op}, {2'b0, f_code(dclk, rsel)});
                end
            end
            check("R2 started", {3'b0, got}, 4'd1);
            wait_n(3);
            check("R2 one pulse", 4'(n_start - s0), 4'd1);
            check("R3 busy low", {2'b0, stat()}, 4'b0000);
            check("R9 eno", {3'b0, en_out_n}, {3'b0, m_last});
            if (abort_mid) begin
                host_en_n = 1'b1;
                wait_n(5);
                check("R10 busy kept", {2'b0, stat()}, 4'b0000);
            end
            eng_done = 1'b1; eng_level = level;
            @(negedge clk);
            eng_done = 1'b0;
            if (!dclk && rsel) ; // write-0 leaves dclk low
            if (dclk && !rsel) m_last = (dn != 2'b00);
            wait_n(3);
            if (abort_mid) begin
                check("R10 pass", {2'b0, stat()}, {2'b0, dn});
            end else begin
                check("R4/R5 after done", {2'b0, stat()},
                      {2'b0, (!dclk && !level) ? 2'b00 : f_pass(m_last, 1, dn)});
                host_dclk = 1'b0;
                wait_n(4);
                check("R5 query", {2'b0, stat()},
                      {2'b0, !level ? 2'b00 : f_pass(m_last, 1, dn)});
                host_dclk = 1'b1;
                wait_n(4);
                check("R6 release dclk", {2'b0, stat()}, {2'b0, f_pass(m_last, 1, dn)});
                check("R9 eno low", {3'b0, en_out_n}, {3'b0, m_last});
            end
        end
        host_en_n = 1'b1;
        wait_n(5);
        check("R6 idle pass", {2'b0, stat()}, {2'b0, dn});
        check("R9 eno idle", {3'b0, en_out_n}, 4'd1);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [1:0] dn;
        int sel;
        void'($urandom(32'h5EED1410));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        check("R1 status", {2'b0, stat()}, 4'b0010);
        check("R1 ovd", {3'b0, eng_ovd}, 4'd0);
        check("R1 no start", 4'(n_start), 4'd0);
        host_en_n = 1'b0; #1;
        check("R1 eno follows", {3'b0, en_out_n}, 4'd0);
        host_en_n = 1'b1;
        wait_n(5);

        // Directed: each operation
        do_slot(1, 1, 2'b01, 1, 0);
        do_slot(1, 1, 2'b10, 0, 0);
        do_slot(0, 1, 2'b11, 0, 0);
        do_slot(0, 0, 2'b11, 0, 0);   // R7 toggle to 1
        do_slot(0, 0, 2'b10, 0, 0);   // R7 toggle to 0
        do_slot(1, 0, 2'b00, 0, 0);   // R8 downstream busy: not last
        do_slot(1, 0, 2'b01, 0, 0);   // R8 no busy: last
        do_slot(1, 1, 2'b00, 1, 0);   // R9 last ignores low inputs
        do_slot(1, 1, 2'b01, 1, 1);   // R10 enable rises mid slot

        // Directed: busy appears only in the done cycle (R8)
        @(negedge clk);
        host_dclk = 1'b1; host_rsel = 1'b0; {dn_in2, dn_in1} = 2'b11;
        wait_n(3);
        host_en_n = 1'b0;
        wait_n(8);
        {dn_in2, dn_in1} = 2'b00;
        wait_n(2);
        eng_done = 1'b1; eng_level = 1'b0;
        @(negedge clk);
        eng_done = 1'b0;
        m_last = 0;
        wait_n(4);
        check("R8 same-cycle busy eno", {3'b0, en_out_n}, 4'd0);
        host_en_n = 1'b1;
        wait_n(5);

        // Random slots
        for (int k = 0; k < 40; k++) begin
            sel = $urandom_range(0, 3);
            dn  = 2'($urandom_range(0, 3));
            case (sel)
                0: do_slot(1, 1, dn, 1'($urandom_range(0, 1)), 0);
                1: do_slot(0, 1, dn, 1'($urandom_range(0, 1)), 0);
                2: do_slot(1, 0, dn, 1'($urandom_range(0, 1)), 0);
                default: do_slot(0, 0, dn, 0, 0);
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule